// File: doc/BRIEF.md
# Compiler-Scheduled Static Crossbar Router

This block is the static-network switch of one mesh tile. It carries two independent crossbars. Each crossbar has five external input links: the north, east, south and west neighbours and the local processor. It has five matching output links. Each crossbar also owns two internal one-word registers. One is a "hold" register that belongs to the router's own pipeline. The other is a "cross" register that the opposite crossbar can read. No word carries a header. Every switching decision comes from a 64-bit routing instruction that software compiles ahead of time. The instruction sets all fourteen output selections of both crossbars at once.

Instructions are fetched in sequence from a local 256-entry instruction memory. An instruction may repeat a programmed number of times and may jump to a target address. An instruction moves its words only when every source it names holds a word and every destination it names has room. Otherwise the whole instruction waits, so the words on each path keep their order. Each input link has a two-entry FIFO that signals ready back to its sender. A word crosses the router in one cycle. On tiles at the edge of the chip, the same links simply connect to external interfaces.

The instruction memory is loaded through a write port that works only while reset is held.

Top module: `static_xbar_router`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every output link is invalid and every input link is ready. Execution starts at instruction address 0.
- R2: The source select for crossbar k, output o sits at instruction bits [(7k+o)*3 +: 3]. Outputs are numbered north 0, east 1, south 2, west 3, processor 4, hold 5, cross 6. Source codes are 0 idle, 1 north, 2 east, 3 south, 4 west, 5 own hold register, 6 the other crossbar's cross register, 7 processor. Link index l of a port array uses the output order 0 to 4.
- R3: A word accepted on an input link at clock edge t appears on the selected output after edge t+1, and not before, when nothing stalls.
- R4: An output link whose ready is low keeps its valid and its data unchanged.
- R5: An instruction executes only when all of its selected sources hold a word and all of its targeted destinations have room. Otherwise no word moves and no input is consumed.
- R6: A source selected by several outputs of one instruction is copied to all of them and consumed once.
- R7: A word written into a hold or cross register can be routed onward by a later instruction. This lets a word pass from one crossbar into the other.
- R8: Each input link buffers two words. Its ready goes low only after a word is accepted while it is full or filling.
- R9: The repeat count in bits [63:51] makes an instruction execute count+1 times before the sequence moves on.
- R10: When bit 42 is set, the next instruction is fetched from the target in bits [50:43]. Otherwise it is fetched from the next address.
- R11: Writes on the load port take effect only while reset is held. Outside reset they are ignored.
- R12: Words leave each output in the order they were routed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Instruction memory write strobe (used only in reset) |
| loadAddr | input | 8 | Instruction memory write address |
| loadData | input | 64 | Instruction word to write |
| linkInValid | input | 2x5 | Input word present, per crossbar and link |
| linkInData | input | 2x5x32 | Input words |
| linkInReady | output | 2x5 | Input FIFO has room |
| linkOutValid | output | 2x5 | Output word present |
| linkOutData | output | 2x5x32 | Output words |
| linkOutReady | input | 2x5 | Receiver accepts the output word |

## Verification
A word accepted at an input edge is due on its output one edge later. Words routed through the hold or cross registers are due one further edge per register. The bench drives and samples on the falling edge, so every handshake is settled when it is read. A scoreboard queue per output takes the expected words, and a monitor compares each word when its handshake completes. Stall and backpressure cases are checked by watching the output and ready ports over several cycles before the missing operand or the output room is supplied.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NET_CNT  = 2;
  localparam int LINK_CNT = 5;
  localparam int OUT_CNT  = 7;
  localparam int SEL_W    = 3;
  localparam int SRC_CNT  = 1 << SEL_W;
  localparam int INSTR_W  = 64;
  localparam int SEL_BITS = NET_CNT * OUT_CNT * SEL_W;
  localparam int JUMP_BIT = SEL_BITS;
  localparam int TGT_LSB  = SEL_BITS + 1;

  localparam int OUT_HOLD  = 5;
  localparam int OUT_CROSS = 6;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t SRC_IDLE  = 3'd0;
  localparam sel_t SRC_HOLD  = 3'd5;
  localparam sel_t SRC_OTHER = 3'd6;
  localparam sel_t SRC_PROC  = 3'd7;

  // source code that reads external link l
  function automatic sel_t linkCode(int l);
    return (l == LINK_CNT - 1) ? SRC_PROC : sel_t'(l + 1);
  endfunction

  typedef struct packed {
    logic                                 fire;
    sel_t [NET_CNT-1:0][OUT_CNT-1:0]      sel;
    logic [NET_CNT-1:0][LINK_CNT-1:0]     popLink;
    logic [NET_CNT-1:0]                   popHold;
    logic [NET_CNT-1:0]                   popCross;
  } xbar_strobe_t;

  typedef struct packed {
    logic [NET_CNT-1:0][LINK_CNT-1:0]     linkValid;
    logic [NET_CNT-1:0]                   holdValid;
    logic [NET_CNT-1:0]                   crossValid;
    logic [NET_CNT-1:0][LINK_CNT-1:0]     outBusy;
  } xbar_status_t;
endpackage

// File: rtl/xbar_in_fifo.sv
module xbar_in_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [W-1:0] inData,
  output logic         inReady,
  input  logic         popEn,
  output logic         headValid,
  output logic [W-1:0] headData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          push, pop;

  function automatic logic [PW-1:0] nextPtr(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign inReady   = (count != CW'(DEPTH));
  assign headValid = (count != '0);
  assign headData  = slots[rdPtr];
  assign push      = inValid && inReady;
  assign pop       = popEn && headValid;

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int IMEM_AW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                loadEn,
  input  logic [IMEM_AW-1:0]  loadAddr,
  input  logic [INSTR_W-1:0]  loadData,
  input  xbar_status_t        status,
  output xbar_strobe_t        strobe
);
  localparam int IMEM_DEPTH = 1 << IMEM_AW;
  localparam int REP_LSB    = TGT_LSB + IMEM_AW;
  localparam int REP_W      = INSTR_W - REP_LSB;

  logic [INSTR_W-1:0] imem [IMEM_DEPTH];
  logic [IMEM_AW-1:0] pc;
  logic [REP_W-1:0]   repCnt;
  logic [INSTR_W-1:0] instr;
  logic               jumpEn;
  logic [IMEM_AW-1:0] jumpTgt;
  logic [REP_W-1:0]   repLimit;

  sel_t [NET_CNT-1:0][OUT_CNT-1:0] sel;
  logic [NET_CNT-1:0][SRC_CNT-1:0] srcUsed;
  logic [NET_CNT-1:0][SRC_CNT-1:0] srcAvail;
  logic srcOk, dstOk, fire;

  always_ff @(posedge clk) begin
    if (rst && loadEn) imem[loadAddr] <= loadData;
  end

  assign instr    = imem[pc];
  assign jumpEn   = instr[JUMP_BIT];
  assign jumpTgt  = instr[TGT_LSB +: IMEM_AW];
  assign repLimit = instr[REP_LSB +: REP_W];

  always_comb begin
    srcUsed = '0;
    for (int k = 0; k < NET_CNT; k++) begin
      for (int o = 0; o < OUT_CNT; o++) begin
        sel[k][o] = instr[(k*OUT_CNT + o)*SEL_W +: SEL_W];
        srcUsed[k][sel[k][o]] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NET_CNT; k++) begin
      srcAvail[k][SRC_IDLE]  = 1'b1;
      srcAvail[k][SRC_HOLD]  = status.holdValid[k];
      srcAvail[k][SRC_OTHER] = status.crossValid[NET_CNT-1-k];
      for (int l = 0; l < LINK_CNT; l++)
        srcAvail[k][linkCode(l)] = status.linkValid[k][l];
    end
  end

  always_comb begin
    srcOk = 1'b1;
    dstOk = 1'b1;
    for (int k = 0; k < NET_CNT; k++) begin
      for (int c = 0; c < SRC_CNT; c++)
        if (srcUsed[k][c] && !srcAvail[k][c]) srcOk = 1'b0;
      for (int o = 0; o < LINK_CNT; o++)
        if (sel[k][o] != SRC_IDLE && status.outBusy[k][o]) dstOk = 1'b0;
      if (sel[k][OUT_HOLD] != SRC_IDLE && status.holdValid[k] && !srcUsed[k][SRC_HOLD])
        dstOk = 1'b0;
      if (sel[k][OUT_CROSS] != SRC_IDLE && status.crossValid[k] &&
          !srcUsed[NET_CNT-1-k][SRC_OTHER])
        dstOk = 1'b0;
    end
  end

  assign fire = srcOk && dstOk && !rst;

  always_comb begin
    strobe.fire = fire;
    strobe.sel  = sel;
    for (int k = 0; k < NET_CNT; k++) begin
      for (int l = 0; l < LINK_CNT; l++)
        strobe.popLink[k][l] = fire && srcUsed[k][linkCode(l)];
      strobe.popHold[k]  = fire && srcUsed[k][SRC_HOLD];
      strobe.popCross[k] = fire && srcUsed[NET_CNT-1-k][SRC_OTHER];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      repCnt <= '0;
    end else if (fire) begin
      if (repCnt == repLimit) begin
        repCnt <= '0;
        pc     <= jumpEn ? jumpTgt : pc + 1'b1;
      end else begin
        repCnt <= repCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NET_CNT-1:0][LINK_CNT-1:0]       linkInValid,
  input  logic [NET_CNT-1:0][LINK_CNT-1:0][DATA_W-1:0] linkInData,
  output logic [NET_CNT-1:0][LINK_CNT-1:0]       linkInReady,
  output logic [NET_CNT-1:0][LINK_CNT-1:0]       linkOutValid,
  output logic [NET_CNT-1:0][LINK_CNT-1:0][DATA_W-1:0] linkOutData,
  input  logic [NET_CNT-1:0][LINK_CNT-1:0]       linkOutReady,
  input  xbar_strobe_t                           strobe,
  output xbar_status_t                           status
);
  logic [NET_CNT-1:0][LINK_CNT-1:0]             headValid;
  logic [NET_CNT-1:0][LINK_CNT-1:0][DATA_W-1:0] headData;
  logic [NET_CNT-1:0]                           holdValid, crossValid;
  logic [NET_CNT-1:0][DATA_W-1:0]               holdData, crossData;
  logic [NET_CNT-1:0][SRC_CNT-1:0][DATA_W-1:0]  srcWord;

  for (genvar k = 0; k < NET_CNT; k++) begin : g_net
    for (genvar l = 0; l < LINK_CNT; l++) begin : g_link
      xbar_in_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .inValid  (linkInValid[k][l]),
        .inData   (linkInData[k][l]),
        .inReady  (linkInReady[k][l]),
        .popEn    (strobe.popLink[k][l]),
        .headValid(headValid[k][l]),
        .headData (headData[k][l])
      );
    end
  end

  always_comb begin
    for (int k = 0; k < NET_CNT; k++) begin
      srcWord[k][SRC_IDLE]  = '0;
      srcWord[k][SRC_HOLD]  = holdData[k];
      srcWord[k][SRC_OTHER] = crossData[NET_CNT-1-k];
      for (int l = 0; l < LINK_CNT; l++)
        srcWord[k][linkCode(l)] = headData[k][l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      linkOutValid <= '0;
      holdValid    <= '0;
      crossValid   <= '0;
    end else begin
      for (int k = 0; k < NET_CNT; k++) begin
        for (int o = 0; o < LINK_CNT; o++) begin
          if (strobe.fire && strobe.sel[k][o] != SRC_IDLE) begin
            linkOutValid[k][o] <= 1'b1;
            linkOutData[k][o]  <= srcWord[k][strobe.sel[k][o]];
          end else if (linkOutReady[k][o]) begin
            linkOutValid[k][o] <= 1'b0;
          end
        end
        if (strobe.fire && strobe.sel[k][OUT_HOLD] != SRC_IDLE) begin
          holdValid[k] <= 1'b1;
          holdData[k]  <= srcWord[k][strobe.sel[k][OUT_HOLD]];
        end else if (strobe.popHold[k]) begin
          holdValid[k] <= 1'b0;
        end
        if (strobe.fire && strobe.sel[k][OUT_CROSS] != SRC_IDLE) begin
          crossValid[k] <= 1'b1;
          crossData[k]  <= srcWord[k][strobe.sel[k][OUT_CROSS]];
        end else if (strobe.popCross[k]) begin
          crossValid[k] <= 1'b0;
        end
      end
    end
  end

  assign status.linkValid  = headValid;
  assign status.holdValid  = holdValid;
  assign status.crossValid = crossValid;
  assign status.outBusy    = linkOutValid & ~linkOutReady;
endmodule

// File: rtl/static_xbar_router.sv
module static_xbar_router
  import xbar_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IMEM_AW    = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         loadEn,
  input  logic [IMEM_AW-1:0]                           loadAddr,
  input  logic [INSTR_W-1:0]                           loadData,
  input  logic [NET_CNT-1:0][LINK_CNT-1:0]             linkInValid,
  input  logic [NET_CNT-1:0][LINK_CNT-1:0][DATA_W-1:0] linkInData,
  output logic [NET_CNT-1:0][LINK_CNT-1:0]             linkInReady,
  output logic [NET_CNT-1:0][LINK_CNT-1:0]             linkOutValid,
  output logic [NET_CNT-1:0][LINK_CNT-1:0][DATA_W-1:0] linkOutData,
  input  logic [NET_CNT-1:0][LINK_CNT-1:0]             linkOutReady
);
  xbar_strobe_t strobe;
  xbar_status_t status;

  xbar_ctrl #(.IMEM_AW(IMEM_AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .loadEn  (loadEn),
    .loadAddr(loadAddr),
    .loadData(loadData),
    .status  (status),
    .strobe  (strobe)
  );

  xbar_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .linkInValid (linkInValid),
    .linkInData  (linkInData),
    .linkInReady (linkInReady),
    .linkOutValid(linkOutValid),
    .linkOutData (linkOutData),
    .linkOutReady(linkOutReady),
    .strobe      (strobe),
    .status      (status)
  );
endmodule

// File: rtl/static_xbar_checker.sv
module static_xbar_checker
  import xbar_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                                         clk,
  input logic                                         rst,
  input logic [NET_CNT-1:0][LINK_CNT-1:0]             linkInValid,
  input logic [NET_CNT-1:0][LINK_CNT-1:0]             linkInReady,
  input logic [NET_CNT-1:0][LINK_CNT-1:0]             linkOutValid,
  input logic [NET_CNT-1:0][LINK_CNT-1:0][DATA_W-1:0] linkOutData,
  input logic [NET_CNT-1:0][LINK_CNT-1:0]             linkOutReady
);
  // R1: first cycle out of reset is clean
  a_r1_clean_start: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (linkOutValid == '0 && (&linkInReady)));

  // R4: a stalled output keeps its valid
  a_r4_keep_valid: assert property (@(posedge clk) disable iff (rst)
    (linkOutValid & ~linkOutReady) != '0 |=>
      ((linkOutValid & $past(linkOutValid & ~linkOutReady)) ==
       $past(linkOutValid & ~linkOutReady)));

  // R8: ready drops only after an accepted word
  a_r8_ready_drop: assert property (@(posedge clk) disable iff (rst)
    ((~linkInReady) & $past(linkInReady) & ~$past(linkInValid)) == '0);

  for (genvar k = 0; k < NET_CNT; k++) begin : g_k
    for (genvar l = 0; l < LINK_CNT; l++) begin : g_l
      // R4: a stalled output keeps its data
      a_r4_keep_data: assert property (@(posedge clk) disable iff (rst)
        linkOutValid[k][l] && !linkOutReady[k][l] |=> $stable(linkOutData[k][l]));
    end
  end
endmodule

bind static_xbar_router static_xbar_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .linkInValid (linkInValid),
  .linkInReady (linkInReady),
  .linkOutValid(linkOutValid),
  .linkOutData (linkOutData),
  .linkOutReady(linkOutReady)
);

// File: tb/sim_static_xbar_router.sv
module sim_static_xbar_router;
  localparam int CLK_PERIOD = 10;
  localparam int NETS = 2;
  localparam int LINKS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadEn = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [63:0] loadData = '0;
  logic [NETS-1:0][LINKS-1:0]        inValid = '0;
  logic [NETS-1:0][LINKS-1:0][31:0]  inData = '0;
  logic [NETS-1:0][LINKS-1:0]        inReady;
  logic [NETS-1:0][LINKS-1:0]        outValid;
  logic [NETS-1:0][LINKS-1:0][31:0]  outData;
  logic [NETS-1:0][LINKS-1:0]        outReady = '1;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  logic [31:0] expQ [NETS*LINKS][$];
  logic [63:0] prog [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  static_xbar_router u0 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .linkInValid(inValid), .linkInData(inData), .linkInReady(inReady),
    .linkOutValid(outValid), .linkOutData(outData), .linkOutReady(outReady)
  );

  // link / output indices: 0 N, 1 E, 2 S, 3 W, 4 proc, 5 hold, 6 cross
  function automatic logic [63:0] route(int net, int outp, int src);
    return 64'(src) << ((net*7 + outp)*3);
  endfunction
  function automatic logic [63:0] jumpTo(int t);
    return (64'd1 << 42) | (64'(t) << 43);
  endfunction
  function automatic logic [63:0] repeatN(int n);
    return 64'(n) << 51;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectWord(int net, int link, logic [31:0] d);
    expQ[net*LINKS + link].push_back(d);
  endtask

  task automatic sendWord(int net, int link, logic [31:0] d);
    @(negedge clk);
    while (!inReady[net][link]) @(negedge clk);
    inValid[net][link] = 1'b1;
    inData[net][link]  = d;
    @(posedge clk);
    #1 inValid[net][link] = 1'b0;
  endtask

  task automatic startProg(int n);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = 8'(i); loadData = prog[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
    rst = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    for (int q = 0; q < NETS*LINKS; q++)
      check({curReq, " drained"}, 32'(expQ[q].size()), 32'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < NETS; k++) begin
        for (int l = 0; l < LINKS; l++) begin
          if (outValid[k][l] && outReady[k][l]) begin
            if (expQ[k*LINKS + l].size() == 0) begin
              checks++; failures++;
              $display("FAIL %s R12 unexpected word net%0d link%0d actual=%h expected=none",
                       curReq, k, l, outData[k][l]);
            end else begin
              check({curReq, " R12 order"}, outData[k][l], expQ[k*LINKS + l].pop_front());
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 + R3 + R2: straight route west -> east on crossbar 0
    prog[0] = route(0, 1, 4) | jumpTo(0);
    startProg(1);
    @(negedge clk);
    check("R1 outValid", 32'(outValid), 32'd0);
    check("R1 inReady", 32'(inReady), 32'h3ff);
    curReq = "R3";
    expectWord(0, 1, 32'hA000_0001);
    sendWord(0, 3, 32'hA000_0001);
    @(negedge clk);
    check("R3 not early", 32'(outValid[0][1]), 32'd0);
    @(negedge clk);
    check("R3 due", 32'(outValid[0][1]), 32'd1);
    check("R3 data", outData[0][1], 32'hA000_0001);
    curReq = "R2";
    for (int i = 0; i < 4; i++) begin
      expectWord(0, 1, 32'hB0 + 32'(i));
      sendWord(0, 3, 32'hB0 + 32'(i));
    end
    settle(6);

    // R6: processor word on crossbar 1 copied to all four neighbours
    curReq = "R6";
    prog[0] = route(1, 0, 7) | route(1, 1, 7) | route(1, 2, 7) | route(1, 3, 7) | jumpTo(0);
    startProg(1);
    for (int i = 0; i < 3; i++) begin
      for (int o = 0; o < 4; o++) expectWord(1, o, 32'hC0 + 32'(i));
      sendWord(1, 4, 32'hC0 + 32'(i));
    end
    settle(6);

    // R5: instruction needs north and east; only north supplied
    curReq = "R5";
    prog[0] = route(0, 2, 1) | route(0, 3, 2) | jumpTo(0);
    startProg(1);
    expectWord(0, 2, 32'hD1);
    expectWord(0, 3, 32'hD2);
    sendWord(0, 0, 32'hD1);
    repeat (5) @(negedge clk);
    check("R5 south stalled", 32'(outValid[0][2]), 32'd0);
    check("R5 west stalled", 32'(outValid[0][3]), 32'd0);
    sendWord(0, 1, 32'hD2);
    settle(5);

    // R7: north -> cross0 -> hold1 (via other crossbar) -> east of crossbar 1
    curReq = "R7";
    prog[0] = route(0, 6, 1);
    prog[1] = route(1, 5, 6);
    prog[2] = route(1, 1, 5) | jumpTo(0);
    startProg(3);
    expectWord(1, 1, 32'hE1);
    expectWord(1, 1, 32'hE2);
    sendWord(0, 0, 32'hE1);
    sendWord(0, 0, 32'hE2);
    settle(10);

    // R9: repeat count 2 routes three words east, then one west
    curReq = "R9";
    prog[0] = route(0, 1, 1) | repeatN(2);
    prog[1] = route(0, 3, 1) | jumpTo(0);
    startProg(2);
    for (int i = 0; i < 3; i++) expectWord(0, 1, 32'hF0 + 32'(i));
    expectWord(0, 3, 32'hF3);
    for (int i = 0; i < 4; i++) sendWord(0, 0, 32'hF0 + 32'(i));
    settle(6);

    // R4 + R8: east output held off, west input fills
    curReq = "R4";
    prog[0] = route(0, 1, 4) | jumpTo(0);
    startProg(1);
    outReady[0][1] = 1'b0;
    for (int i = 0; i < 3; i++) expectWord(0, 1, 32'h70 + 32'(i));
    for (int i = 0; i < 3; i++) sendWord(0, 3, 32'h70 + 32'(i));
    @(negedge clk);
    check("R8 input full", 32'(inReady[0][3]), 32'd0);
    check("R4 valid held", 32'(outValid[0][1]), 32'd1);
    repeat (4) @(negedge clk);
    check("R4 data held", outData[0][1], 32'h70);
    check("R8 still full", 32'(inReady[0][3]), 32'd0);
    @(posedge clk); #1 outReady[0][1] = 1'b1;
    settle(6);

    // R10 + R11: jump skips address 1; late load of address 0 ignored
    curReq = "R10";
    prog[0] = route(0, 1, 1) | jumpTo(2);
    prog[1] = route(0, 3, 1);
    prog[2] = route(0, 2, 1) | jumpTo(0);
    startProg(3);
    for (int i = 0; i < 4; i++) expectWord(0, (i % 2 == 0) ? 1 : 2, 32'h90 + 32'(i));
    for (int i = 0; i < 4; i++) sendWord(0, 0, 32'h90 + 32'(i));
    settle(4);
    curReq = "R11";
    @(negedge clk);
    loadEn = 1'b1; loadAddr = 8'd0; loadData = route(0, 3, 1) | jumpTo(0);
    @(negedge clk);
    loadEn = 1'b0;
    for (int i = 0; i < 2; i++) expectWord(0, (i % 2 == 0) ? 1 : 2, 32'h60 + 32'(i));
    for (int i = 0; i < 2; i++) sendWord(0, 0, 32'h60 + 32'(i));
    settle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule